// File: doc/BRIEF.md
# VIA interrupt flag controller

This block holds the interrupt state of a versatile interface adapter: a seven-bit flag register, a seven-bit enable register and an eight-bit control register that sets how the four handshake lines are sensed. Each port (A and B) has two handshake lines. Both are edge sensitive, and a control bit for each line picks the rising or the falling edge. A shift-complete input and two timer-expiry inputs set their own flags directly. The single active-high interrupt request is the OR of all flags that are enabled.

A byte-wide register bus reaches the flag, enable and control registers. It also carries the port-data and shift addresses. Their data paths live elsewhere, but an access to them has side effects here. Any access to a port acknowledges that port's handshake flags. Reading the shift address acknowledges the shift flag. Bus strobes last one cycle. Read data is combinational from the current state, and side effects take effect at the clock edge that ends the access.

Top module: `via_irq_ctrl`

## Requirements
- R1: After reset, the flag register reads 0x00, the control register reads 0x00, the enable register reads 0x80 and the interrupt request is low.
- R2: The interrupt request is high exactly when some flag bit and the matching enable bit are both 1.
- R3: A read at address 13 returns the flags in bits 6:0, with bit 7 set when the interrupt request is high.
- R4: A write at address 13 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R5: A write at address 14 with data bit 7 = 1 sets the enable bits given as 1 in bits 6:0. With bit 7 = 0 it clears them. A read at address 14 returns the enable bits with bit 7 forced to 1.
- R6: Flag bit 1 (A line 1), bit 0 (A line 2), bit 4 (B line 1) and bit 3 (B line 2) are set only by a level change on their line. The change must be rising when the line's polarity bit is 1 and falling when it is 0. The polarity bits are control bits 0, 2, 4 and 6 in that order.
- R7: Flag bit 2 is set in every cycle the shift-complete input is high, with no edge check. A read at address 10 clears it. A write at address 10 does not clear it.
- R8: A read or write at address 0 (port B) clears flag bit 4. It also clears flag bit 3 unless control bit 5 (B line 2 independent) is 1.
- R9: A read or write at address 1 or 15 (port A) clears flag bit 1. It also clears flag bit 0 unless control bit 1 (A line 2 independent) is 1.
- R10: Timer-1 and timer-2 expiry pulses set flag bits 6 and 5. If a set and a clear reach the same flag in the same cycle, the set wins.
- R11: A write at address 12 loads the control register, and a read there returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data (zero for addresses whose data lives outside) |
| porta_ctl1_i | input | 1 | Port A handshake line 1 |
| porta_ctl2_i | input | 1 | Port A handshake line 2 |
| portb_ctl1_i | input | 1 | Port B handshake line 1 |
| portb_ctl2_i | input | 1 | Port B handshake line 2 |
| shift_done_i | input | 1 | Shift-complete request (level) |
| tmr1_exp_i | input | 1 | Timer 1 expiry pulse |
| tmr2_exp_i | input | 1 | Timer 2 expiry pulse |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The checker watches the following on every cycle:
- the interrupt level against the flag and enable registers;
- the summary bit and the forced bit 7 on reads;
- the set and clear arithmetic of enable writes;
- the setting of the timer and shift flags by their inputs.

Some behaviours only the bench's scenarios can show. These are edge polarity on each handshake line, port accesses acknowledging flags with and without independent mode, and the no-handshake port A address. The bench also covers the shift flag ignoring writes, a set beating a clear in the same cycle, and reset in mid-run.

// File: rtl/via_irq_pkg.sv
package via_irq_pkg;
   // flag bit positions (fixed; software decodes them)
   localparam int unsigned FB_A2    = 0;
   localparam int unsigned FB_A1    = 1;
   localparam int unsigned FB_SHIFT = 2;
   localparam int unsigned FB_B2    = 3;
   localparam int unsigned FB_B1    = 4;
   localparam int unsigned FB_T2    = 5;
   localparam int unsigned FB_T1    = 6;

   // control field layout, repeated per port with this stride
   localparam int unsigned CF_L1_POL = 0;
   localparam int unsigned CF_L2_IND = 1;
   localparam int unsigned CF_L2_POL = 2;
   localparam int unsigned CF_STRIDE = 4;

   localparam int unsigned N_PORTS = 2;

   function automatic int unsigned line1_flag(input int unsigned port);
      return (port == 0) ? FB_A1 : FB_B1;
   endfunction

   function automatic int unsigned line2_flag(input int unsigned port);
      return (port == 0) ? FB_A2 : FB_B2;
   endfunction
endpackage

// File: rtl/via_edge_det.sv
module via_edge_det #(
   parameter int unsigned N_LINES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_LINES-1:0] line_i,
   input  logic [N_LINES-1:0] pol_i,
   output logic [N_LINES-1:0] hit_o
);
   logic [N_LINES-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= line_i;
   end

   // a change whose new level equals the selected polarity
   assign hit_o = (line_i ^ prev_q) & ~(line_i ^ pol_i);
endmodule

// File: rtl/via_flag_bank.sv
module via_flag_bank #(
   parameter int unsigned N_FLAGS = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_FLAGS-1:0] set_i,
   input  logic [N_FLAGS-1:0] clr_i,
   output logic [N_FLAGS-1:0] flags_o
);
   logic [N_FLAGS-1:0] flags_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/via_enable_reg.sv
module via_enable_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-2:0] en_o
);
   localparam int unsigned N_EN = DATA_W - 1;

   logic [N_EN-1:0] en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (wr_i) begin
         if (wdata_i[DATA_W-1]) en_q <= en_q | wdata_i[N_EN-1:0];
         else                   en_q <= en_q & ~wdata_i[N_EN-1:0];
      end
   end

   assign en_o = en_q;
endmodule

// File: rtl/via_irq_ctrl.sv
module via_irq_ctrl #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned ADR_PORTB    = 0,
   parameter int unsigned ADR_PORTA    = 1,
   parameter int unsigned ADR_SHIFT    = 10,
   parameter int unsigned ADR_CTRL     = 12,
   parameter int unsigned ADR_FLAG     = 13,
   parameter int unsigned ADR_ENAB     = 14,
   parameter int unsigned ADR_PORTA_NH = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              porta_ctl1_i,
   input  logic              porta_ctl2_i,
   input  logic              portb_ctl1_i,
   input  logic              portb_ctl2_i,
   input  logic              shift_done_i,
   input  logic              tmr1_exp_i,
   input  logic              tmr2_exp_i,
   output logic              irq_o
);
   import via_irq_pkg::*;

   localparam int unsigned N_FLAGS = DATA_W - 1;
   localparam int unsigned SUM_BIT = DATA_W - 1;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("via_irq_ctrl: flag layout needs DATA_W of 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("via_irq_ctrl: 16 register slots need ADDR_W >= 4");
      end
   endgenerate

   // ---------------- access decode ----------------
   logic access;
   logic wr_ctrl, wr_flag, wr_enab, rd_shift;
   logic [N_PORTS-1:0] port_hit;

   assign access   = bus_rd_i | bus_wr_i;
   assign wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_CTRL));
   assign wr_flag  = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_FLAG));
   assign wr_enab  = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_ENAB));
   assign rd_shift = bus_rd_i && (bus_addr_i == ADDR_W'(ADR_SHIFT));
   assign port_hit[0] = access && ((bus_addr_i == ADDR_W'(ADR_PORTA)) ||
                                   (bus_addr_i == ADDR_W'(ADR_PORTA_NH)));
   assign port_hit[1] = access && (bus_addr_i == ADDR_W'(ADR_PORTB));

   // ---------------- control register ----------------
   logic [DATA_W-1:0] ctrl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata_i;
   end

   // ---------------- handshake edge sensing, one detector per port ----------------
   logic [N_PORTS-1:0] ctl1_vec, ctl2_vec;
   logic [1:0]         port_hits [N_PORTS];

   assign ctl1_vec = {portb_ctl1_i, porta_ctl1_i};
   assign ctl2_vec = {portb_ctl2_i, porta_ctl2_i};

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_port
         logic [1:0] pol;
         assign pol[0] = ctrl_q[p*CF_STRIDE + CF_L1_POL];
         assign pol[1] = ctrl_q[p*CF_STRIDE + CF_L2_POL];

         via_edge_det #(.N_LINES(2)) u_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .line_i ({ctl2_vec[p], ctl1_vec[p]}),
            .pol_i  (pol),
            .hit_o  (port_hits[p])
         );
      end
   endgenerate

   // ---------------- set and clear vectors ----------------
   logic [N_FLAGS-1:0] set_vec, clr_vec;

   always_comb begin
      set_vec = '0;
      for (int unsigned p = 0; p < N_PORTS; p++) begin
         set_vec[line1_flag(p)] = port_hits[p][0];
         set_vec[line2_flag(p)] = port_hits[p][1];
      end
      set_vec[FB_SHIFT] = shift_done_i;
      set_vec[FB_T1]    = tmr1_exp_i;
      set_vec[FB_T2]    = tmr2_exp_i;
   end

   always_comb begin
      clr_vec = '0;
      if (wr_flag) clr_vec = bus_wdata_i[N_FLAGS-1:0];
      if (rd_shift) clr_vec[FB_SHIFT] = 1'b1;
      for (int unsigned p = 0; p < N_PORTS; p++) begin
         if (port_hit[p]) begin
            clr_vec[line1_flag(p)] = 1'b1;
            if (!ctrl_q[p*CF_STRIDE + CF_L2_IND]) clr_vec[line2_flag(p)] = 1'b1;
         end
      end
   end

   // ---------------- state ----------------
   logic [N_FLAGS-1:0] flags_q;
   logic [N_FLAGS-1:0] en_q;

   via_flag_bank #(.N_FLAGS(N_FLAGS)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .flags_o (flags_q)
   );

   via_enable_reg #(.DATA_W(DATA_W)) u_enab (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_enab),
      .wdata_i (bus_wdata_i),
      .en_o    (en_q)
   );

   assign irq_o = |(flags_q & en_q);

   // ---------------- read path ----------------
   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(ADR_FLAG)) begin
         bus_rdata_o[N_FLAGS-1:0] = flags_q;
         bus_rdata_o[SUM_BIT]     = irq_o;
      end else if (bus_addr_i == ADDR_W'(ADR_ENAB)) begin
         bus_rdata_o[N_FLAGS-1:0] = en_q;
         bus_rdata_o[SUM_BIT]     = 1'b1;
      end else if (bus_addr_i == ADDR_W'(ADR_CTRL)) begin
         bus_rdata_o = ctrl_q;
      end
   end
endmodule

// File: rtl/via_irq_ctrl_chk.sv
module via_irq_ctrl_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned ADR_FLAG = 13,
   parameter int unsigned ADR_ENAB = 14
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_rd_i,
   input logic              bus_wr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              shift_done_i,
   input logic              tmr1_exp_i,
   input logic              tmr2_exp_i,
   input logic [DATA_W-2:0] flags_q,
   input logic [DATA_W-2:0] en_q,
   input logic              irq_o
);
   localparam int unsigned NF = DATA_W - 1;

   // R2
   irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (|(flags_q & en_q)));

   // R3
   summary_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && bus_addr_i == ADDR_W'(ADR_FLAG)) |-> bus_rdata_o[DATA_W-1] == irq_o);

   // R5
   enab_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && bus_addr_i == ADDR_W'(ADR_ENAB)) |-> bus_rdata_o[DATA_W-1]);

   // R5
   enab_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ADDR_W'(ADR_ENAB) && bus_wdata_i[DATA_W-1])
      |=> en_q == ($past(en_q) | $past(bus_wdata_i[NF-1:0])));

   // R5
   enab_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ADDR_W'(ADR_ENAB) && !bus_wdata_i[DATA_W-1])
      |=> en_q == ($past(en_q) & ~$past(bus_wdata_i[NF-1:0])));

   // R10
   tmr1_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr1_exp_i |=> flags_q[6]);

   // R10
   tmr2_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr2_exp_i |=> flags_q[5]);

   // R7
   shift_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_done_i |=> flags_q[2]);
endmodule

bind via_irq_ctrl via_irq_ctrl_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .ADR_FLAG (ADR_FLAG),
   .ADR_ENAB (ADR_ENAB)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_addr_i   (bus_addr_i),
   .bus_rd_i     (bus_rd_i),
   .bus_wr_i     (bus_wr_i),
   .bus_wdata_i  (bus_wdata_i),
   .bus_rdata_o  (bus_rdata_o),
   .shift_done_i (shift_done_i),
   .tmr1_exp_i   (tmr1_exp_i),
   .tmr2_exp_i   (tmr2_exp_i),
   .flags_q      (flags_q),
   .en_q         (en_q),
   .irq_o        (irq_o)
);

// File: tb/via_irq_ctrl_test.sv
`timescale 1ns/1ps
module via_irq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       rd = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] lines = '0;
   logic       shift = 1'b0, t1 = 1'b0, t2 = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   via_irq_ctrl uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bus_addr_i   (addr),
      .bus_rd_i     (rd),
      .bus_wr_i     (wr),
      .bus_wdata_i  (wdata),
      .bus_rdata_o  (rdata),
      .porta_ctl1_i (lines[0]),
      .porta_ctl2_i (lines[1]),
      .portb_ctl1_i (lines[2]),
      .portb_ctl2_i (lines[3]),
      .shift_done_i (shift),
      .tmr1_exp_i   (t1),
      .tmr2_exp_i   (t2),
      .irq_o        (irq)
   );

   // vector: {req, op, addr, data, expect}
   // ops: 0 write, 1 read+compare, 2 set lines {B2,B1,A2,A1}, 3 pulse {t1,t2,-,-,shift@2}, 4 compare irq
   localparam int NV = 65;
   localparam logic [27:0] VEC [NV] = '{
      28'h1_1_D_00_00, // R1 flags clear
      28'h1_1_E_00_80, // R1 enable reads 0x80
      28'h1_1_C_00_00, // R1 control clear
      28'h1_4_0_00_00, // R1 irq low
      28'hB_0_C_11_00, // R11 A1 rising, B1 rising
      28'hB_1_C_00_11, // R11
      28'h6_2_0_01_00, // R6 A1 rises
      28'h6_1_D_00_02, // R6
      28'h2_4_0_00_00, // R2 not enabled
      28'h5_0_E_82_00, // R5 enable bit1
      28'h3_1_D_00_82, // R3 summary
      28'h2_4_0_00_01, // R2
      28'h6_2_0_00_00, // R6 A1 falls: ignored
      28'h6_1_D_00_82, // R6
      28'h6_2_0_02_00, // R6 A2 rises: wrong edge
      28'h6_1_D_00_82, // R6
      28'h6_2_0_00_00, // R6 A2 falls
      28'h6_1_D_00_83, // R6
      28'h9_1_1_00_00, // R9 port A read
      28'h9_1_D_00_00, // R9 both A flags cleared
      28'h2_4_0_00_00, // R2
      28'h6_2_0_04_00, // R6 B1 rises
      28'h6_2_0_0C_00, // R6 B2 rises: wrong edge
      28'h6_2_0_04_00, // R6 B2 falls
      28'h6_1_D_00_18, // R6
      28'hB_0_C_31_00, // R11 B2 independent
      28'h8_0_0_AA_00, // R8 port B write
      28'h8_1_D_00_08, // R8 B2 kept
      28'h4_0_D_08_00, // R4
      28'h4_1_D_00_00, // R4
      28'h7_3_0_04_00, // R7 shift pulse
      28'h7_1_D_00_04, // R7
      28'h7_0_A_55_00, // R7 write SR: no clear
      28'h7_1_D_00_04, // R7
      28'h7_1_A_00_00, // R7 read SR
      28'h7_1_D_00_00, // R7
      28'hA_3_0_60_00, // R10 both timers
      28'hA_1_D_00_60, // R10
      28'h5_0_E_7F_00, // R5 clear all enables
      28'h5_1_E_00_80, // R5
      28'h5_0_E_C0_00, // R5 set bit6
      28'h5_1_E_00_C0, // R5
      28'h3_1_D_00_E0, // R3
      28'h2_4_0_00_01, // R2
      28'h4_0_D_40_00, // R4 clear t1 only
      28'h4_1_D_00_20, // R4
      28'h2_4_0_00_00, // R2
      28'h6_2_0_05_00, // R6 A1 rises
      28'h6_1_D_00_22, // R6
      28'h9_1_F_00_00, // R9 no-handshake port A read
      28'h9_1_D_00_20, // R9
      28'hB_0_C_03_00, // R11 A2 independent
      28'h6_2_0_07_00, // R6 A2 rises: wrong edge
      28'h6_2_0_05_00, // R6 A2 falls
      28'h9_0_1_00_00, // R9 port A write
      28'h9_1_D_00_21, // R9 A2 kept
      28'h4_0_D_7F_00, // R4
      28'h4_1_D_00_00, // R4
      28'hB_0_C_00_00, // R11 all falling, none independent
      28'h6_2_0_01_00, // R6 B1 falls
      28'h6_2_0_09_00, // R6 B2 rises: wrong edge
      28'h6_2_0_01_00, // R6 B2 falls
      28'h6_1_D_00_18, // R6
      28'h8_1_0_00_00, // R8 port B read
      28'h8_1_D_00_00  // R8 both B flags cleared
   };

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic idle_bus();
      rd = 0; wr = 0; shift = 0; t1 = 0; t2 = 0;
   endtask

   task automatic run_vec(input logic [27:0] v);
      int req = int'(v[27:24]);
      @(negedge clk);
      idle_bus();
      case (v[23:20])
         4'h0: begin addr = v[19:16]; wdata = v[15:8]; wr = 1; end
         4'h1: begin addr = v[19:16]; rd = 1; #1 check(req, rdata, v[7:0]); end
         4'h2: lines = v[11:8];
         4'h3: begin shift = v[10]; t2 = v[13]; t1 = v[14]; end
         default: begin #1 check(req, {7'd0, irq}, v[7:0]); end
      endcase
      @(posedge clk);
   endtask

   task automatic read_chk(input int req, input logic [3:0] a, input logic [7:0] exp);
      @(negedge clk);
      idle_bus();
      addr = a; rd = 1;
      #1 check(req, rdata, exp);
      @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R10 timer set beats a same-cycle clear (enable still bit6)
      @(negedge clk);
      idle_bus();
      t1 = 1; addr = 4'hD; wdata = 8'h40; wr = 1;
      @(posedge clk);
      read_chk(10, 4'hD, 8'hC0);

      // R7 shift set beats a same-cycle SR read
      @(negedge clk);
      idle_bus();
      shift = 1; addr = 4'hA; rd = 1;
      @(posedge clk);
      read_chk(7, 4'hD, 8'hC4);

      // R1 reset in mid-run
      @(negedge clk);
      idle_bus();
      lines = '0;
      @(negedge clk) rst_n = 0;
      #1 check(1, {7'd0, irq}, 8'h00);
      repeat (2) @(negedge clk);
      rst_n = 1;
      read_chk(1, 4'hD, 8'h00);
      read_chk(1, 4'hE, 8'h80);
      read_chk(1, 4'hC, 8'h00);

      @(negedge clk) idle_bus();
      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         report();
         $finish;
      end
   end
endmodule